// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This block is the combinational bit-manipulation datapath of an eight-bit processor core. It takes one operand byte, the current flag byte, a four-bit operation code and a three-bit bit index. In the same cycle it returns a result byte, a write enable for the destination and the new flag byte. Operand fetch, indexed addressing and the register file sit outside the block. The caller writes `result_o` back when `wr_en_o` is high and always latches `flags_o`.

The block covers circular rotates, rotates through carry, the arithmetic and logical shifts, a left shift that inserts a one, and bit test, set and reset. It also has four accumulator short forms, which follow a narrower flag policy. A full-form rotate or shift rebuilds the flag byte from the result. A short form changes only carry, half-carry and add/subtract. A bit test changes only zero, half-carry and add/subtract. Set, reset and the idle code leave the flags alone.

The block has no clock and no state. The house state-machine layout is therefore replaced by an enumerated operation decode, built as one unique case that picks the result source and one of four flag policies: keep, full, short and test.

Top module: `rot_shift_bit_unit`

## Requirements
- R1: `op_i` codes are 0 idle, 1 rotate-left-circular, 2 rotate-right-circular, 3 rotate-left-through-carry, 4 rotate-right-through-carry, 5 shift-left-arithmetic, 6 shift-right-arithmetic, 7 shift-left-insert-one, 8 shift-right-logical, 9 bit test, 10 bit set, 11 bit reset, 12 short circular left, 13 short circular right, 14 short through-carry left, 15 short through-carry right. The idle code returns the operand unchanged, with `wr_en_o` low and `flags_o` equal to `flags_i`.
- R2: In a circular rotate (codes 1, 2, 12 and 13), the bit shifted out fills the vacated end bit and also becomes the carry.
- R3: In a rotate through carry (codes 3, 4, 14 and 15), the incoming carry (`flags_i` bit 0) fills the vacated end bit, and the bit shifted out becomes the carry.
- R4: Shift-left-arithmetic puts 0 in bit 0. Shift-right-arithmetic keeps bit 7. Shift-right-logical puts 0 in bit 7. Each of them moves the bit shifted out into carry.
- R5: Shift-left-insert-one sets result bit 0 to 1 and moves operand bit 7 into carry.
- R6: The flag byte layout is sign bit 7, zero bit 6, half-carry bit 4, parity bit 2, add/subtract bit 1 and carry bit 0. Codes 1 to 8 write sign (result bit 7), zero (result is 0), parity (1 when the result has an even number of ones) and carry. They clear half-carry, add/subtract and bits 5 and 3.
- R7: Codes 12 to 15 set carry to the bit shifted out and clear half-carry and add/subtract. Bits 7, 6, 5, 3 and 2 are kept from `flags_i`.
- R8: Bit test (code 9) sets zero when operand bit `bit_idx_i` is 0 and clears it otherwise. It sets half-carry, clears add/subtract, keeps the other flag bits, returns the operand and holds `wr_en_o` low.
- R9: Bit set (code 10) and bit reset (code 11) force only the operand bit selected by `bit_idx_i` to 1 or 0 and return `flags_i` unchanged.
- R10: `wr_en_o` is high for codes 1 to 8 and 10 to 15, and low for codes 0 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| op_i | input | 4 | Operation code (see R1) |
| bit_idx_i | input | 3 | Bit index for test, set and reset |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 8 | New flag byte |

## Verification
The main collision happens in the through-carry rotates. In the same evaluation, the incoming carry enters the vacated end bit while the departing end bit replaces that carry. An error that swaps or drops either path can hide when the two values agree. The bench provokes this by sweeping every operand byte against two complementary flag bytes, one with carry set and one with carry clear, so the two paths disagree in half of all cases. Each result and flag byte is then judged against an arithmetic model built on multiplication, division and remainders. The bit operations are swept over all eight indices, where test, set and reset share the same index decode.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int FLAG_W = 8;

    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_H = 4;
    localparam int FB_P = 2;
    localparam int FB_N = 1;
    localparam int FB_C = 0;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_RLC   = 4'd1,
        OP_RRC   = 4'd2,
        OP_RL    = 4'd3,
        OP_RR    = 4'd4,
        OP_SLA   = 4'd5,
        OP_SRA   = 4'd6,
        OP_SLI   = 4'd7,
        OP_SRL   = 4'd8,
        OP_BTST  = 4'd9,
        OP_BSET  = 4'd10,
        OP_BCLR  = 4'd11,
        OP_ARLC  = 4'd12,
        OP_ARRC  = 4'd13,
        OP_ARL   = 4'd14,
        OP_ARR   = 4'd15
    } rsb_op_e;

    typedef enum logic [1:0] {
        FP_KEEP  = 2'd0,
        FP_FULL  = 2'd1,
        FP_SHORT = 2'd2,
        FP_TEST  = 2'd3
    } flag_pol_e;

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] val_i,
    input  logic         carry_i,
    input  rsb_op_e      op_i,
    output logic [W-1:0] res_o,
    output logic         out_bit_o
);

    logic go_left;
    logic fill_bit;

    always_comb begin
        go_left  = 1'b0;
        fill_bit = 1'b0;
        unique case (op_i)
            OP_RLC, OP_ARLC: begin go_left = 1'b1; fill_bit = val_i[W-1]; end
            OP_RL,  OP_ARL:  begin go_left = 1'b1; fill_bit = carry_i;    end
            OP_SLA:          begin go_left = 1'b1; fill_bit = 1'b0;       end
            OP_SLI:          begin go_left = 1'b1; fill_bit = 1'b1;       end
            OP_RRC, OP_ARRC: begin go_left = 1'b0; fill_bit = val_i[0];   end
            OP_RR,  OP_ARR:  begin go_left = 1'b0; fill_bit = carry_i;    end
            OP_SRA:          begin go_left = 1'b0; fill_bit = val_i[W-1]; end
            OP_SRL:          begin go_left = 1'b0; fill_bit = 1'b0;       end
            default:         begin go_left = 1'b0; fill_bit = 1'b0;       end
        endcase
    end

    always_comb begin
        if (go_left) begin
            res_o     = {val_i[W-2:0], fill_bit};
            out_bit_o = val_i[W-1];
        end else begin
            res_o     = {fill_bit, val_i[W-1:1]};
            out_bit_o = val_i[0];
        end
    end

    always_comb begin
        if (!$isunknown({val_i, carry_i, op_i})) begin
            if (op_i == OP_RLC || op_i == OP_RRC || op_i == OP_ARLC || op_i == OP_ARRC)
                a_r2_circular_keeps_ones: assert ($countones(res_o) == $countones(val_i))
                    else $error("R2 circular rotate changed the count of ones");
            if (op_i == OP_RL || op_i == OP_ARL)
                a_r3_carry_enters_lsb: assert (res_o[0] == carry_i)
                    else $error("R3 incoming carry not placed in bit 0");
        end
    end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic [W-1:0]  val_i,
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  set_o,
    output logic [W-1:0]  clr_o,
    output logic          tested_o
);

    logic [W-1:0] sel_mask;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign sel_mask[g] = (idx_i == IW'(g));
    end

    assign set_o    = val_i | sel_mask;
    assign clr_o    = val_i & ~sel_mask;
    assign tested_o = |(val_i & sel_mask);

    always_comb begin
        if (!$isunknown({val_i, idx_i})) begin
            a_r9_one_bit_touched: assert ($countones((set_o ^ val_i) | (clr_o ^ val_i)) <= 1)
                else $error("R9 more than one bit altered");
        end
    end

endmodule

// File: rtl/rsb_flags.sv
module rsb_flags
    import rsb_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int FW = FLAG_W
) (
    input  flag_pol_e     pol_i,
    input  logic [FW-1:0] flags_i,
    input  logic [W-1:0]  res_i,
    input  logic          out_bit_i,
    input  logic          tested_i,
    output logic [FW-1:0] flags_o
);

    logic [W:0] par_chain;

    assign par_chain[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ res_i[g];
    end

    always_comb begin
        flags_o = flags_i;
        unique case (pol_i)
            FP_KEEP: begin
                flags_o = flags_i;
            end
            FP_FULL: begin
                flags_o       = '0;
                flags_o[FB_S] = res_i[W-1];
                flags_o[FB_Z] = (res_i == '0);
                flags_o[FB_P] = ~par_chain[W];
                flags_o[FB_C] = out_bit_i;
            end
            FP_SHORT: begin
                flags_o[FB_H] = 1'b0;
                flags_o[FB_N] = 1'b0;
                flags_o[FB_C] = out_bit_i;
            end
            FP_TEST: begin
                flags_o[FB_Z] = ~tested_i;
                flags_o[FB_H] = 1'b1;
                flags_o[FB_N] = 1'b0;
            end
            default: flags_o = flags_i;
        endcase
    end

    always_comb begin
        if (!$isunknown({pol_i, res_i, flags_i})) begin
            if (pol_i == FP_FULL)
                a_r6_parity_even: assert (flags_o[FB_P] == (($countones(res_i) % 2) == 0))
                    else $error("R6 parity flag disagrees with result");
        end
    end

endmodule

// File: rtl/rot_shift_bit_unit.sv
module rot_shift_bit_unit
    import rsb_pkg::*;
(
    input  logic [7:0] operand_i,
    input  logic [7:0] flags_i,
    input  logic [3:0] op_i,
    input  logic [2:0] bit_idx_i,
    output logic [7:0] result_o,
    output logic       wr_en_o,
    output logic [7:0] flags_o
);

    rsb_op_e          op;
    flag_pol_e        pol;
    logic [DATA_W-1:0] sh_res;
    logic              sh_out;
    logic [DATA_W-1:0] bs_res;
    logic [DATA_W-1:0] bc_res;
    logic              tested;

    assign op = rsb_op_e'(op_i);

    rsb_shifter #(.W(DATA_W)) u_shift (
        .val_i     (operand_i),
        .carry_i   (flags_i[FB_C]),
        .op_i      (op),
        .res_o     (sh_res),
        .out_bit_o (sh_out)
    );

    rsb_bitop #(.W(DATA_W), .IW(IDX_W)) u_bit (
        .val_i    (operand_i),
        .idx_i    (bit_idx_i),
        .set_o    (bs_res),
        .clr_o    (bc_res),
        .tested_o (tested)
    );

    always_comb begin
        result_o = operand_i;
        wr_en_o  = 1'b0;
        pol      = FP_KEEP;
        unique case (op)
            OP_IDLE: begin
                result_o = operand_i; wr_en_o = 1'b0; pol = FP_KEEP;
            end
            OP_RLC, OP_RRC, OP_RL, OP_RR,
            OP_SLA, OP_SRA, OP_SLI, OP_SRL: begin
                result_o = sh_res; wr_en_o = 1'b1; pol = FP_FULL;
            end
            OP_ARLC, OP_ARRC, OP_ARL, OP_ARR: begin
                result_o = sh_res; wr_en_o = 1'b1; pol = FP_SHORT;
            end
            OP_BTST: begin
                result_o = operand_i; wr_en_o = 1'b0; pol = FP_TEST;
            end
            OP_BSET: begin
                result_o = bs_res; wr_en_o = 1'b1; pol = FP_KEEP;
            end
            OP_BCLR: begin
                result_o = bc_res; wr_en_o = 1'b1; pol = FP_KEEP;
            end
            default: begin
                result_o = operand_i; wr_en_o = 1'b0; pol = FP_KEEP;
            end
        endcase
    end

    rsb_flags #(.W(DATA_W), .FW(FLAG_W)) u_flags (
        .pol_i     (pol),
        .flags_i   (flags_i),
        .res_i     (result_o),
        .out_bit_i (sh_out),
        .tested_i  (tested),
        .flags_o   (flags_o)
    );

    always_comb begin
        if (!$isunknown({op_i, operand_i, flags_i, bit_idx_i})) begin
            if (op == OP_BSET || op == OP_BCLR)
                a_r9_flags_untouched: assert (flags_o == flags_i && result_o[bit_idx_i] == (op == OP_BSET))
                    else $error("R9 set/reset altered flags or missed the bit");
            if (op == OP_BTST)
                a_r8_test_no_write: assert (!wr_en_o && result_o == operand_i)
                    else $error("R8 bit test produced a write");
            if (op >= OP_ARLC)
                a_r7_short_keeps_szp: assert (flags_o[FB_S] == flags_i[FB_S] && flags_o[FB_Z] == flags_i[FB_Z]
                                              && flags_o[FB_P] == flags_i[FB_P])
                    else $error("R7 short form altered sign, zero or parity");
            if (op == OP_SRA)
                a_r4_sra_holds_msb: assert (result_o[7] == operand_i[7])
                    else $error("R4 arithmetic right shift lost bit 7");
        end
    end

endmodule

// File: tb/rot_shift_bit_unit_tb_top.sv
module rot_shift_bit_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk;
    logic       rst_n;
    logic [7:0] operand_i;
    logic [7:0] flags_i;
    logic [3:0] op_i;
    logic [2:0] bit_idx_i;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [7:0] flags_o;

    int n_checks;
    int n_fails;
    bit done;

    rot_shift_bit_unit dut_i (
        .operand_i (operand_i),
        .flags_i   (flags_i),
        .op_i      (op_i),
        .bit_idx_i (bit_idx_i),
        .result_o  (result_o),
        .wr_en_o   (wr_en_o),
        .flags_o   (flags_o)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic string req_of(int op);
        if (op == 0) return "R1";
        if (op == 1 || op == 2) return "R2";
        if (op == 3 || op == 4) return "R3";
        if (op == 5 || op == 6 || op == 8) return "R4";
        if (op == 7) return "R5";
        if (op == 9) return "R8";
        if (op == 10 || op == 11) return "R9";
        if (op == 12 || op == 13) return "R7";
        return "R7";
    endfunction

    function automatic int ones_of(int v);
        int n = 0;
        for (int k = 0; k < 8; k++) n += (v >> k) % 2;
        return n;
    endfunction

    // returns wr*65536 + res*256 + flags
    function automatic int model(int op, int v, int f, int idx);
        int msb = v / 128;
        int lsb = v % 2;
        int c   = f % 2;
        int res = v;
        int out = 0;
        int wr  = 1;
        int fl  = f;
        int pw  = 1 << idx;
        int b   = (v / pw) % 2;
        case (op)
            1, 12: begin res = (v * 2) % 256 + msb;       out = msb; end
            2, 13: begin res = v / 2 + lsb * 128;         out = lsb; end
            3, 14: begin res = (v * 2) % 256 + c;         out = msb; end
            4, 15: begin res = v / 2 + c * 128;           out = lsb; end
            5:     begin res = (v * 2) % 256;             out = msb; end
            6:     begin res = v / 2 + msb * 128;         out = lsb; end
            7:     begin res = (v * 2) % 256 + 1;         out = msb; end
            8:     begin res = v / 2;                     out = lsb; end
            9:     begin res = v; wr = 0; end
            10:    begin res = (b == 1) ? v : v + pw; end
            11:    begin res = (b == 1) ? v - pw : v; end
            default: begin res = v; wr = 0; end
        endcase
        if (op >= 1 && op <= 8)
            fl = (res / 128) * 128 + ((res == 0) ? 64 : 0)
               + ((ones_of(res) % 2 == 0) ? 4 : 0) + out;
        else if (op >= 12)
            fl = (f / 32) * 32 + ((f / 8) % 2) * 8 + ((f / 4) % 2) * 4 + out;
        else if (op == 9)
            fl = (f / 128) * 128 + ((b == 0) ? 64 : 0) + ((f / 32) % 2) * 32 + 16
               + ((f / 8) % 2) * 8 + ((f / 4) % 2) * 4 + c;
        return wr * 65536 + res * 256 + fl;
    endfunction

    task automatic apply_and_check(int op, int v, int f, int idx);
        int e;
        op_i      = 4'(op);
        operand_i = 8'(v);
        flags_i   = 8'(f);
        bit_idx_i = 3'(idx);
        #2;
        e = model(op, v, f, idx);
        n_checks++;
        if (result_o !== 8'((e / 256) % 256) || flags_o !== 8'(e % 256)
            || wr_en_o !== 1'((e / 65536) % 2)) begin
            n_fails++;
            $display("FAIL %s op=%0d v=%02h f=%02h idx=%0d: actual res=%02h fl=%02h wr=%0b expected res=%02h fl=%02h wr=%0d",
                     req_of(op), op, v, f, idx, result_o, flags_o, wr_en_o,
                     (e / 256) % 256, e % 256, e / 65536);
        end
        // R10: write enable cross-check on code class
        n_checks++;
        if (wr_en_o !== ((op != 0 && op != 9) ? 1'b1 : 1'b0)) begin
            n_fails++;
            $display("FAIL R10 op=%0d actual wr=%0b expected wr=%0b",
                     op, wr_en_o, (op != 0 && op != 9));
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        op_i = 4'd0; operand_i = 8'h00; flags_i = 8'h00; bit_idx_i = 3'd0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle code as the starting state
        apply_and_check(0, 8'h5A, 8'hA9, 0);
        // R2 R3 R4 R5 R6 R7 R8 R9 R10: full sweep
        for (int op = 0; op < 16; op++) begin
            for (int v = 0; v < 256; v++) begin
                for (int fp = 0; fp < 2; fp++) begin
                    int f = (fp == 1) ? 8'hA9 : 8'h56;
                    if (op >= 9 && op <= 11) begin
                        for (int idx = 0; idx < 8; idx++)
                            apply_and_check(op, v, f, idx);
                    end else begin
                        apply_and_check(op, v, f, v % 8);
                    end
                end
            end
        end
        // R6 corner: zero result from shift-right-logical of 1
        apply_and_check(8, 8'h01, 8'hFF, 0);
        // R5 corner: insert-one from all ones
        apply_and_check(7, 8'hFF, 8'h00, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule